// File: doc/BRIEF.md
# Gated Square Wave Divider

A single programmable counter channel that turns its input clock into a continuous square wave. The wave's period equals a 16-bit count N written through a small write port. A strobe that marks a fresh control word re-arms the channel. It then holds the output high and waits for a count. The first clock edge after the count arrives loads N. The counter then steps down by two on each clock, and the output flips each time a half period runs out. For odd N the high phase is one clock longer than the low phase.

An enable input pauses counting while it is low. While it is low it also forces the output high through a combinational path. A low-to-high change on it restarts the current period from the latest written count. A count written while the wave is running leaves the current half period alone. It takes effect at the next half-period boundary, or at the next restart if a restart comes first.

Top module: `sqw_divider`

## Requirements
- R1: While reset is asserted and right after it, wave_o is high and the channel is idle.
- R2: One clock after ctl_stb_i, wave_o is high, and it stays high with no counting until a count is written.
- R3: When idle, a count written on clock edge W is loaded on edge W+1, and the high phase is measured from that edge.
- R4: For an even count N, wave_o is high for N/2 clocks and low for N/2 clocks, repeating without end.
- R5: For an odd count N (3 or more), wave_o is high for (N+1)/2 clocks and low for (N-1)/2 clocks, repeating.
- R6: A written count of 0 acts as 65536, giving a high phase of 32768 clocks.
- R7: While gate_i is low the internal count does not change.
- R8: While gate_i is low, wave_o is high with no clock edge needed.
- R9: A rising gate_i sampled on edge E reloads the count on edge E+1, and the high phase of a full period starts there.
- R10: A count written during a half period does not change that half. It is used from the next reload onward.
- R11: A count written while gate_i is low is used by the reload caused by the next rising gate_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one wave period is N of its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Count enable; its rising edge restarts the period |
| ctl_stb_i | input | 1 | Control word written: re-arm and idle |
| wr_stb_i | input | 1 | Count write strobe |
| wr_count_i | input | 16 | Count value; 0 means 65536 |
| wave_o | output | 1 | Square wave output |

## Verification
A wrong step size or a wrong expiry compare shows up as a phase length off by one or more clocks. It appears in the first half period after a load, so half a period at most. A reload from the wrong count register shows up at the first boundary after a write or a restart. Phase lengths are therefore measured for several full periods across even, odd and extreme counts, and around writes and enable edges. A missing combinational force-high would show at once as a low output while the enable is low.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W:0] cnt_t;
endpackage

// File: rtl/sqw_gate_edge.sv
module sqw_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic trig_o
);
  logic gate_q;
  logic trig_n;

  always_comb trig_n = gate_i & ~gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      gate_q <= gate_i;
      trig_o <= trig_n;
    end
  end
endmodule

// File: rtl/sqw_step.sv
module sqw_step #(
  parameter int unsigned W = 16
) (
  input  logic [W:0] cnt_i,
  input  logic       level_i,
  output logic [W:0] step_o
);
  // odd values only occur on the first clock after a (re)load
  always_comb begin
    if (cnt_i[0]) step_o = level_i ? (W+1)'(1) : (W+1)'(3);
    else          step_o = (W+1)'(2);
  end
endmodule

// File: rtl/sqw_core.sv
module sqw_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_i,
  input  logic         trig_i,
  input  logic         ctl_stb_i,
  input  logic         wr_stb_i,
  input  logic [W-1:0] wr_count_i,
  output logic         out_q,
  output logic [W:0]   cnt_q,
  output logic         run_q,
  output logic         start_q
);
  logic [W-1:0] count_q, count_n;
  logic [W:0]   cnt_n, load_val, step;
  logic         out_n, run_n, start_n;

  always_comb load_val = (count_q == '0) ? {1'b1, {W{1'b0}}} : {1'b0, count_q};

  sqw_step #(.W(W)) u_step (.cnt_i(cnt_q), .level_i(out_q), .step_o(step));

  always_comb begin
    count_n = count_q;
    cnt_n   = cnt_q;
    out_n   = out_q;
    run_n   = run_q;
    start_n = start_q;
    if (wr_stb_i) count_n = wr_count_i;
    if (ctl_stb_i) begin
      run_n   = 1'b0;
      out_n   = 1'b1;
      start_n = wr_stb_i;
    end else if (start_q) begin
      cnt_n   = load_val;
      out_n   = 1'b1;
      run_n   = 1'b1;
      start_n = 1'b0;
    end else if (!run_q) begin
      if (wr_stb_i) start_n = 1'b1;
    end else if (trig_i) begin
      cnt_n = load_val;
      out_n = 1'b1;
    end else if (!gate_i) begin
      out_n = 1'b1;
    end else if (cnt_q <= step) begin
      cnt_n = load_val;
      out_n = ~out_q;
    end else begin
      cnt_n = cnt_q - step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cnt_q   <= {1'b1, {W{1'b0}}};
      out_q   <= 1'b1;
      run_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      count_q <= count_n;
      cnt_q   <= cnt_n;
      out_q   <= out_n;
      run_q   <= run_n;
      start_q <= start_n;
    end
  end
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gate_i,
  input  logic        ctl_stb_i,
  input  logic        wr_stb_i,
  input  logic [15:0] wr_count_i,
  output logic        wave_o
);
  import sqw_pkg::*;

  logic trig;
  logic out_q;
  cnt_t cnt_q;
  logic run_q;
  logic start_q;

  sqw_gate_edge u_edge (.clk(clk), .rst_n(rst_n), .gate_i(gate_i), .trig_o(trig));

  sqw_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .trig_i(trig),
    .ctl_stb_i(ctl_stb_i), .wr_stb_i(wr_stb_i), .wr_count_i(wr_count_i),
    .out_q(out_q), .cnt_q(cnt_q), .run_q(run_q), .start_q(start_q)
  );

  // low enable forces the output high without a clock edge
  always_comb wave_o = out_q | ~gate_i;
endmodule

// File: rtl/sqw_divider_chk.sv
module sqw_divider_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gate_i,
  input logic        ctl_stb_i,
  input logic        wave_o,
  input logic        trig,
  input logic        run_q,
  input logic        start_q,
  input logic [16:0] cnt_q
);
  a_r8_gate_low_high: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |-> wave_o);

  a_r2_ctl_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stb_i |=> (!run_q && wave_o));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !gate_i && !trig && !start_q && !ctl_stb_i) |=> $stable(cnt_q));

  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != 17'd0 && cnt_q <= 17'd65536));

  a_r4_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && gate_i && !trig && !start_q && !ctl_stb_i && !cnt_q[0] && cnt_q > 17'd2)
      |=> cnt_q == $past(cnt_q) - 17'd2);

  a_r9_trig_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && trig && !start_q && !ctl_stb_i) |=> wave_o);
endmodule

bind sqw_divider sqw_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .ctl_stb_i(ctl_stb_i),
  .wave_o(wave_o), .trig(trig), .run_q(run_q), .start_q(start_q), .cnt_q(cnt_q)
);

// File: tb/sqw_divider_tb.sv
module sqw_divider_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 7;
  // stimulus count, expected high clocks, expected low clocks
  localparam int VN[NV] = '{2, 3, 4, 5, 7, 10, 11};
  localparam int VH[NV] = '{1, 2, 2, 3, 4, 5, 6};
  localparam int VL[NV] = '{1, 1, 2, 2, 3, 5, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_i = 1'b1;
  logic ctl_stb_i = 1'b0;
  logic wr_stb_i = 1'b0;
  logic [15:0] wr_count_i = '0;
  logic wave_o;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  sqw_divider u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count consecutive negedge samples at the given level
  task automatic phase(input logic lvl, output int n);
    n = 0;
    while (wave_o == lvl && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // re-arm, write n, return at the negedge after the load edge
  task automatic start_count(input int n);
    @(negedge clk); ctl_stb_i = 1'b1;
    @(negedge clk); ctl_stb_i = 1'b0; wr_stb_i = 1'b1; wr_count_i = 16'(n);
    @(negedge clk); wr_stb_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int h, l, hi_run;
    repeat (3) @(negedge clk);
    chk("R1 wave high in reset", int'(wave_o), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 wave high idle after reset", int'(wave_o), 1);

    // table of counts
    for (int i = 0; i < NV; i++) begin
      start_count(VN[i]);
      phase(1'b1, h); chk($sformatf("R3/R4/R5 high N=%0d", VN[i]), h, VH[i]);
      phase(1'b0, l); chk($sformatf("R4/R5 low N=%0d", VN[i]), l, VL[i]);
      phase(1'b1, h); chk($sformatf("R4/R5 repeat high N=%0d", VN[i]), h, VH[i]);
    end

    // R6: zero means 65536
    start_count(0);
    phase(1'b1, h); chk("R6 zero count high phase", h, 32768);

    // R2: control word idles the channel
    @(negedge clk); ctl_stb_i = 1'b1;
    @(negedge clk); ctl_stb_i = 1'b0;
    hi_run = 0;
    for (int k = 0; k < 20; k++) begin
      if (wave_o) hi_run++;
      @(negedge clk);
    end
    chk("R2 no toggling before a count is written", hi_run, 20);

    // R10: write during a high half, adopted at the boundary
    start_count(10);
    wr_stb_i = 1'b1; wr_count_i = 16'd4;
    @(negedge clk); wr_stb_i = 1'b0;
    phase(1'b1, h); chk("R10 current half kept", h + 1, 5);
    phase(1'b0, l); chk("R10 new count after boundary low", l, 2);
    phase(1'b1, h); chk("R10 new count high", h, 2);

    // R8/R7/R11/R9: gate low during low half, write, then retrigger
    start_count(10);
    phase(1'b1, h);
    repeat (2) @(negedge clk);
    chk("R8 wave low before gate drop", int'(wave_o), 0);
    gate_i = 1'b0;
    #1;
    chk("R8 wave forced high without clock", int'(wave_o), 1);
    wr_stb_i = 1'b1; wr_count_i = 16'd6;
    @(negedge clk); wr_stb_i = 1'b0;
    hi_run = 0;
    for (int k = 0; k < 30; k++) begin
      if (wave_o) hi_run++;
      @(negedge clk);
    end
    chk("R7 frozen: wave stays high while gate low", hi_run, 30);
    gate_i = 1'b1;
    @(negedge clk);   // edge E samples the rise
    @(negedge clk);   // edge E+1 reloads
    phase(1'b1, h); chk("R9/R11 high after trigger with new count", h, 3);
    phase(1'b0, l); chk("R11 low after trigger with new count", l, 3);
    phase(1'b1, h); chk("R9 repeat high", h, 3);

    // R1: reset mid-low returns high
    phase(1'b0, l);
    rst_n = 1'b0;
    #1;
    chk("R1 asynchronous reset sets wave high", int'(wave_o), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle after reset", int'(wave_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule